// File: doc/BRIEF.md
# Sprite Fetch Slot Sequencer

This block sequences the per-line memory fetches for the eight hardware sprites of a raster video generator. It is clocked once per half-cycle. The raster timing arrives as three inputs: the low byte of the line number, the cycle number within the line (1 to 63), and a phase bit. The phase bit is 0 in the video half and 1 in the processor half. From these the block decides when each sprite's memory DMA begins and ends and when its display flag rises and falls. It also decides what lands in each sprite's three-byte line buffer.

Each sprite owns a fetch slot of two consecutive cycles. The first half of the first cycle reads the sprite pointer. The remaining three halves read the three data bytes. A sprite whose horizontal position lies far enough right begins displaying on the very line its vertical register matches. This happens before its DMA has been switched on. A slot that passes in that state carries no real sprite access. The buffer then receives 0xFF in the two processor halves and a ghost byte in the video half. The ghost byte is read from the top address of the 16 KB bank. If the processor drives the bus during a processor half of that slot, its data is taken in place of 0xFF.

Top module: `sprite_fetch_seq`

## Requirements
- R1: While reset is high and on the first edge after it, every display flag is 0 and every line buffer is 0. With no DMA slot in progress, the fetch address is 0x3FFF.
- R2: An enabled sprite whose Y register equals the raster line starts DMA in the video half of cycle 58 of that line. If its X position is below 0x164, its display flag stays 0 for the rest of that line and rises on the first half-cycle of the next line. A sprite with its enable bit clear never starts.
- R3: During a DMA slot, the pointer is read from address {matrix base[3:0], 7'h7F, sprite index[2:0]}. The three data bytes are read from {pointer, count}, {pointer, count+1} and {pointer, count+2}. The first byte fills buffer bits 23:16 and the last byte fills bits 7:0.
- R4: The data count starts at 0, advances by 3 after each fetched line, and DMA stops after the 21st line. The display flag remains set for the next line and clears at the start of the line after it.
- R5: An enabled sprite with X at or above 0x164 raises its display flag on the first half-cycle of the line that matches its Y register.
- R6: In a slot of a displayed sprite without DMA, the video half reads address 0x3FFF into the middle byte. Both processor halves load 0xFF when no processor access is present. A write to that address changes the middle byte on the next such slot.
- R7: A processor access strobe in a processor half of such a slot loads the processor bus byte into that buffer byte.
- R8: Sprite 0's slot begins on the DMA start edge, so sprite 0 gets a real fetch even on a same-line start.
- R9: A sprite with neither DMA nor a same-line start keeps its buffer unchanged through its slot. This includes the extra display line after DMA ends.
- R10: Sprite n's slot starts at cycle 58+2n, wrapping past 63 to 1, giving 58, 60, 62, 1, 3, 5, 7, 9. Buffers change only within slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| raster_line | input | 8 | Low byte of the current raster line |
| line_cyc | input | 7 | Cycle within the line, 1 to 63 |
| cpu_half | input | 1 | 0 in the video half, 1 in the processor half |
| spr_en | input | 8 | Per-sprite enable |
| spr_y | input | 8x8 | Per-sprite vertical register |
| spr_x | input | 8x9 | Per-sprite horizontal position |
| mtx_base | input | 4 | Video matrix base, in 1 KB units |
| mem_rdata | input | 8 | Memory read data for the current address |
| cpu_acc | input | 1 | Processor touches a chip register this half-cycle |
| cpu_bus | input | 8 | Data on the processor bus |
| spr_buf | output | 8x24 | Per-sprite line buffer |
| spr_disp | output | 8 | Per-sprite display flag |
| mem_addr | output | 14 | Fetch address within the bank |

## Verification
The hardest state to reach is a same-line start whose slot sees processor data. The sprite's Y must match the line, its X must be at or above the threshold, and the strobe must fall in the processor half of that sprite's own slot. All of this must happen before cycle 58 switches DMA on. The bench owns the raster timing inputs, so it steps to the exact line, cycle and phase and raises the strobe only across the chosen slot. Between two such starts, the bench rewrites the top bank byte so that the ghost byte can be seen to follow memory.

// File: rtl/sprfs_pkg.sv
package sprfs_pkg;
    localparam int BYTE_W      = 8;
    localparam int CYC_W       = 7;
    localparam int ADDR_W      = 14;
    localparam int MC_W        = 6;
    localparam int LINE_CYCLES = 63;
    localparam logic [ADDR_W-1:0] ADDR_IDLE = '1;

    typedef enum logic [1:0] {
        PH_PTR = 2'd0,
        PH_B0  = 2'd1,
        PH_B1  = 2'd2,
        PH_B2  = 2'd3
    } slot_ph_e;

    typedef struct packed {
        logic     hit;
        slot_ph_e ph;
    } slot_pos_t;

    typedef struct packed {
        logic                  dma;
        logic                  late;
        logic                  tail;
        logic                  disp;
        logic [MC_W-1:0]       mc;
        logic [BYTE_W-1:0]     ptr;
        logic [3*BYTE_W-1:0]   data;
    } spr_state_t;

    function automatic logic [CYC_W-1:0] slot_cycle(int first, int idx);
        int s;
        s = first + 2 * idx;
        if (s > LINE_CYCLES) s = s - LINE_CYCLES;
        return CYC_W'(s);
    endfunction

    function automatic slot_pos_t slot_pos(logic [CYC_W-1:0] cyc, logic half,
                                           logic [CYC_W-1:0] first);
        slot_pos_t p;
        logic second;
        second = (cyc == first + 7'd1);
        p.hit  = (cyc == first) || second;
        p.ph   = slot_ph_e'({second, half});
        return p;
    endfunction

    function automatic logic any_slot(logic [CYC_W-1:0] cyc, int first, int nspr);
        logic r;
        logic [CYC_W-1:0] s;
        r = 1'b0;
        for (int n = 0; n < nspr; n++) begin
            s = slot_cycle(first, n);
            if (cyc == s || cyc == s + 7'd1) r = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/spr_addr_mux.sv
module spr_addr_mux
    import sprfs_pkg::*;
#(
    parameter int NSPR = 8
) (
    input  logic [NSPR-1:0]             req,
    input  logic [NSPR-1:0][ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0]           mem_addr
);
    always_comb begin
        mem_addr = ADDR_IDLE;
        for (int i = 0; i < NSPR; i++) begin
            if (req[i]) mem_addr = addr[i];
        end
    end
endmodule

// File: rtl/spr_slot_unit.sv
module spr_slot_unit
    import sprfs_pkg::*;
#(
    parameter int               IDX     = 0,
    parameter logic [CYC_W-1:0] FIRST   = 7'd58,
    parameter logic [8:0]       LATE_X  = 9'h164,
    parameter logic [MC_W-1:0]  MC_STEP = 6'd3,
    parameter logic [MC_W-1:0]  MC_LAST = 6'd63
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            line_lo,
    input  logic [CYC_W-1:0]      cyc,
    input  logic                  half,
    input  logic                  line_start,
    input  logic                  dma_chk,
    input  logic                  en,
    input  logic [7:0]            y,
    input  logic [8:0]            x,
    input  logic [3:0]            mtx_base,
    input  logic [BYTE_W-1:0]     mem_rdata,
    input  logic                  cpu_acc,
    input  logic [BYTE_W-1:0]     cpu_bus,
    output logic [3*BYTE_W-1:0]   line_buf,
    output logic                  disp,
    output logic                  req,
    output logic [ADDR_W-1:0]     addr
);
    spr_state_t q, d;
    slot_pos_t  pos;
    logic       y_hit, start, dma_eff, fill, late_hit;
    logic [BYTE_W-1:0] fetched;

    always_comb begin
        pos      = slot_pos(cyc, half, FIRST);
        y_hit    = en && (y == line_lo);
        late_hit = y_hit && (x >= LATE_X);
        start    = dma_chk && y_hit && !q.dma;
        dma_eff  = q.dma || start;
        fill     = pos.hit && (dma_eff || q.late);
        req      = pos.hit && dma_eff;

        if (!dma_eff && (pos.ph == PH_B0 || pos.ph == PH_B2))
            fetched = cpu_acc ? cpu_bus : 8'hFF;
        else
            fetched = mem_rdata;

        unique case (pos.ph)
            PH_PTR:  addr = {mtx_base, 7'h7F, 3'(IDX)};
            PH_B0:   addr = {q.ptr, q.mc};
            PH_B1:   addr = {q.ptr, q.mc + 6'd1};
            default: addr = {q.ptr, q.mc + 6'd2};
        endcase

        d = q;
        if (start) begin
            d.dma  = 1'b1;
            d.mc   = '0;
            d.late = 1'b0;
        end
        if (line_start) begin
            d.disp = q.dma || q.tail || late_hit;
            d.tail = 1'b0;
            if (late_hit && !q.dma) d.late = 1'b1;
        end
        if (fill) begin
            unique case (pos.ph)
                PH_PTR: if (dma_eff) d.ptr = mem_rdata;
                PH_B0:  d.data[23:16] = fetched;
                PH_B1:  d.data[15:8]  = fetched;
                default: begin
                    d.data[7:0] = fetched;
                    if (dma_eff) begin
                        d.mc = q.mc + MC_STEP;
                        if (q.mc + MC_STEP == MC_LAST) begin
                            d.dma  = 1'b0;
                            d.tail = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign line_buf = q.data;
    assign disp     = q.disp;
endmodule

// File: rtl/sprite_fetch_seq.sv
module sprite_fetch_seq
    import sprfs_pkg::*;
#(
    parameter int         NSPR       = 8,
    parameter int         FIRST_SLOT = 58,
    parameter int         DMA_CYC    = 58,
    parameter logic [8:0] LATE_X     = 9'h164,
    parameter int         MC_STEP    = 3,
    parameter int         MC_LAST    = 63
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [7:0]                      raster_line,
    input  logic [CYC_W-1:0]                line_cyc,
    input  logic                            cpu_half,
    input  logic [NSPR-1:0]                 spr_en,
    input  logic [NSPR-1:0][7:0]            spr_y,
    input  logic [NSPR-1:0][8:0]            spr_x,
    input  logic [3:0]                      mtx_base,
    input  logic [BYTE_W-1:0]               mem_rdata,
    input  logic                            cpu_acc,
    input  logic [BYTE_W-1:0]               cpu_bus,
    output logic [NSPR-1:0][3*BYTE_W-1:0]   spr_buf,
    output logic [NSPR-1:0]                 spr_disp,
    output logic [ADDR_W-1:0]               mem_addr
);
    logic                        line_start, dma_chk;
    logic [NSPR-1:0]             req;
    logic [NSPR-1:0][ADDR_W-1:0] addr;

    assign line_start = (line_cyc == 7'd1) && !cpu_half;
    assign dma_chk    = (line_cyc == CYC_W'(DMA_CYC)) && !cpu_half;

    for (genvar i = 0; i < NSPR; i++) begin : g_spr
        localparam logic [CYC_W-1:0] FS = slot_cycle(FIRST_SLOT, i);
        spr_slot_unit #(
            .IDX(i), .FIRST(FS), .LATE_X(LATE_X),
            .MC_STEP(MC_W'(MC_STEP)), .MC_LAST(MC_W'(MC_LAST))
        ) u_unit (
            .clk(clk), .rst(rst), .line_lo(raster_line), .cyc(line_cyc),
            .half(cpu_half), .line_start(line_start), .dma_chk(dma_chk),
            .en(spr_en[i]), .y(spr_y[i]), .x(spr_x[i]), .mtx_base(mtx_base),
            .mem_rdata(mem_rdata), .cpu_acc(cpu_acc), .cpu_bus(cpu_bus),
            .line_buf(spr_buf[i]), .disp(spr_disp[i]),
            .req(req[i]), .addr(addr[i])
        );
    end

    spr_addr_mux #(.NSPR(NSPR)) u_mux (
        .req(req), .addr(addr), .mem_addr(mem_addr)
    );
endmodule

// File: rtl/sprite_fetch_chk.sv
module sprite_fetch_chk
    import sprfs_pkg::*;
#(
    parameter int NSPR       = 8,
    parameter int FIRST_SLOT = 58
) (
    input logic                          clk,
    input logic                          rst,
    input logic [CYC_W-1:0]              line_cyc,
    input logic                          cpu_half,
    input logic [NSPR-1:0]               spr_disp,
    input logic [NSPR-1:0][3*BYTE_W-1:0] spr_buf,
    input logic [ADDR_W-1:0]             mem_addr
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (spr_disp == '0 && spr_buf == '0));

    assert_addr_only_in_slot_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_addr != ADDR_IDLE) |-> any_slot(line_cyc, FIRST_SLOT, NSPR));

    for (genvar i = 0; i < NSPR; i++) begin : g_chk
        localparam logic [CYC_W-1:0] S = slot_cycle(FIRST_SLOT, i);

        assert_disp_rise_at_line_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(spr_disp[i]) |-> ($past(line_cyc) == 7'd1 && !$past(cpu_half)));

        assert_disp_fall_at_line_R4: assert property (@(posedge clk) disable iff (rst)
            $fell(spr_disp[i]) |-> ($past(line_cyc) == 7'd1 && !$past(cpu_half)));

        assert_buf_only_in_slot_R10: assert property (@(posedge clk) disable iff (rst)
            !$stable(spr_buf[i]) |-> ($past(line_cyc) == S || $past(line_cyc) == S + 7'd1));
    end
endmodule

bind sprite_fetch_seq sprite_fetch_chk #(.NSPR(NSPR), .FIRST_SLOT(FIRST_SLOT)) u_chk (
    .clk(clk), .rst(rst), .line_cyc(line_cyc), .cpu_half(cpu_half),
    .spr_disp(spr_disp), .spr_buf(spr_buf), .mem_addr(mem_addr)
);

// File: tb/test_sprite_fetch_seq.sv
`timescale 1ns/1ps
module test_sprite_fetch_seq;
    logic             clk = 1'b0;
    logic             rst;
    logic [8:0]       t_line;
    logic [6:0]       t_cyc;
    logic             t_half;
    logic [7:0]       spr_en;
    logic [7:0][7:0]  spr_y;
    logic [7:0][8:0]  spr_x;
    logic [7:0]       mem_rdata;
    logic             cpu_acc;
    logic [7:0]       cpu_bus;
    logic [7:0][23:0] spr_buf;
    logic [7:0]       spr_disp;
    logic [13:0]      mem_addr;
    logic [7:0]       ghost;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sprite_fetch_seq i_sprite_fetch_seq (
        .clk(clk), .rst(rst), .raster_line(t_line[7:0]), .line_cyc(t_cyc),
        .cpu_half(t_half), .spr_en(spr_en), .spr_y(spr_y), .spr_x(spr_x),
        .mtx_base(4'h1), .mem_rdata(mem_rdata), .cpu_acc(cpu_acc),
        .cpu_bus(cpu_bus), .spr_buf(spr_buf), .spr_disp(spr_disp),
        .mem_addr(mem_addr)
    );

    function automatic logic [7:0] memfn(logic [13:0] a, logic [7:0] g);
        if (a == 14'h3FFF) return g;
        if (a[13:3] == {4'h1, 7'h7F}) return 8'h20 + {5'd0, a[2:0]};
        return (a[7:0] * 8'd3) ^ {2'b00, a[13:8]};
    endfunction

    always_comb mem_rdata = memfn(mem_addr, ghost);

    function automatic logic [23:0] real_bytes(int s, int m);
        logic [7:0] p;
        p = 8'h20 + 8'(s);
        return {memfn({p, 6'(m)}, 8'h0), memfn({p, 6'(m + 1)}, 8'h0),
                memfn({p, 6'(m + 2)}, 8'h0)};
    endfunction

    function automatic int slot_of(int n);
        int s;
        s = 58 + 2 * n;
        if (s > 63) s = s - 63;
        return s;
    endfunction

    typedef struct packed {
        logic [2:0]  spr;
        logic [8:0]  line;
        logic [8:0]  xpos;
        logic [7:0]  gh;
        logic        inj;
        logic [7:0]  cdata;
        logic [23:0] exp;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{3'd3, 9'd50, 9'h164, 8'h3C, 1'b0, 8'h00, 24'hFF3CFF},
        '{3'd5, 9'd60, 9'h1F0, 8'hA7, 1'b0, 8'h00, 24'hFFA7FF},
        '{3'd6, 9'd70, 9'h170, 8'hA7, 1'b1, 8'h12, 24'h12A712},
        '{3'd7, 9'd80, 9'h1A0, 8'h00, 1'b1, 8'h99, 24'h990099}
    };

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic adv();
        @(negedge clk);
        if (t_half) begin
            t_half = 1'b0;
            if (t_cyc == 7'd63) begin
                t_cyc  = 7'd1;
                t_line = t_line + 9'd1;
            end else begin
                t_cyc = t_cyc + 7'd1;
            end
        end else begin
            t_half = 1'b1;
        end
    endtask

    task automatic goto(int l, int c, int h);
        while (!(t_line == 9'(l) && t_cyc == 7'(c) && t_half == 1'(h))) adv();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; t_line = '0; t_cyc = 7'd1; t_half = 1'b0;
        spr_en = '0; spr_x = '0; cpu_acc = 1'b0; cpu_bus = '0; ghost = 8'h3C;
        for (int i = 0; i < 8; i++) spr_y[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 disp", 32'(spr_disp), 32'h0);
        check("R1 buf", 32'(spr_buf[1] | spr_buf[5]), 32'h0);
        goto(0, 20, 0); #1;
        check("R1 idle addr", 32'(mem_addr), 32'h3FFF);

        // R2/R3/R4 normal start for sprite 1; sprite 2 matches Y but is disabled
        goto(5, 20, 0);
        spr_en[1] = 1'b1; spr_y[1] = 8'd10; spr_x[1] = 9'h020;
        spr_y[2] = 8'd10; spr_x[2] = 9'h1F0;
        goto(10, 60, 0); #1;
        check("R10 R3 pointer addr sprite1", 32'(mem_addr), 32'h07F9);
        goto(10, 62, 0);
        check("R3 first line bytes", 32'(spr_buf[1]), 32'(real_bytes(1, 0)));
        goto(10, 63, 1);
        check("R2 no display on match line", 32'(spr_disp[1]), 32'h0);
        goto(11, 2, 0);
        check("R2 display next line", 32'(spr_disp[1]), 32'h1);
        check("R2 disabled sprite stays off", 32'(spr_disp[2]), 32'h0);
        goto(11, 62, 0);
        check("R4 count step 3", 32'(spr_buf[1]), 32'(real_bytes(1, 3)));
        goto(30, 62, 0);
        check("R4 21st line bytes", 32'(spr_buf[1]), 32'(real_bytes(1, 60)));
        goto(31, 2, 0);
        check("R4 tail line shown", 32'(spr_disp[1]), 32'h1);
        goto(31, 62, 0);
        check("R9 no refill after DMA end", 32'(spr_buf[1]), 32'(real_bytes(1, 60)));
        goto(32, 2, 0);
        check("R4 display off", 32'(spr_disp[1]), 32'h0);

        // R5/R8 late sprite 0, R2 boundary X just below threshold on sprite 4
        goto(35, 20, 0);
        spr_en[0] = 1'b1; spr_y[0] = 8'd40; spr_x[0] = 9'h180;
        spr_en[4] = 1'b1; spr_y[4] = 8'd40; spr_x[4] = 9'h163;
        goto(40, 1, 1);
        check("R5 same-line display sprite0", 32'(spr_disp[0]), 32'h1);
        check("R2 X=0x163 not same-line", 32'(spr_disp[4]), 32'h0);
        goto(40, 5, 0);
        check("R9 sprite4 buffer untouched", 32'(spr_buf[4]), 32'h0);
        goto(40, 60, 0);
        check("R8 sprite0 real fetch", 32'(spr_buf[0]), 32'(real_bytes(0, 0)));
        goto(41, 3, 0); #1;
        check("R10 wrapped slot pointer addr", 32'(mem_addr), 32'h07FC);
        goto(41, 5, 0);
        check("R2 sprite4 display next line", 32'(spr_disp[4]), 32'h1);
        check("R3 sprite4 bytes", 32'(spr_buf[4]), 32'(real_bytes(4, 0)));

        // R5/R6/R7 same-line starts without DMA
        for (int v = 0; v < 4; v++) begin
            int s;
            int c0;
            s  = int'(VECS[v].spr);
            c0 = slot_of(s);
            goto(int'(VECS[v].line) - 1, 20, 0);
            ghost = VECS[v].gh;
            spr_en[s] = 1'b1; spr_y[s] = VECS[v].line[7:0]; spr_x[s] = VECS[v].xpos;
            goto(int'(VECS[v].line), c0, 0);
            cpu_acc = VECS[v].inj; cpu_bus = VECS[v].cdata;
            goto(int'(VECS[v].line), c0 + 1, 0); #1;
            check("R6 ghost address", 32'(mem_addr), 32'h3FFF);
            goto(int'(VECS[v].line), c0 + 2, 0);
            cpu_acc = 1'b0;
            check("R5 same-line display", 32'(spr_disp[s]), 32'h1);
            check(VECS[v].inj ? "R7 processor bytes" : "R6 pattern bytes",
                  32'(spr_buf[s]), 32'(VECS[v].exp));
        end

        check("R9 disabled sprite buffer", 32'(spr_buf[2]), 32'h0);
        check("R2 disabled sprite display", 32'(spr_disp[2]), 32'h0);
        summary();
    end
endmodule